// File: doc/BRIEF.md
# Multi-bit trace monitor subunit

The block watches a multi-bit sample bus qualified by a valid strobe and turns accepted samples into trace elements on a registered element stream. Collection is switched on and off by a control bit, and a second control bit chooses between emitting every valid sample and emitting only samples whose value differs from the last element emitted. The change-detection reference is dropped whenever collection is off, so the first sample after enabling always yields an element.

Two masked comparators look at every accepted sample. One raises a single-cycle trigger pulse for the cross-trigger fabric. The other can raise a timestamp request. Timestamp requests may also come from an external cross-trigger request input or from every element produced, each source gated by its own enable bit. Software configures everything through a simple write/read register port with a combinational read path. That port also holds a parameterised bank of mux-select words, which the block stores for the surrounding logic and returns on read.

Top module: `mbit_trace_monitor`

## Requirements
- R1: After reset every register reads zero and elem_valid_o, trig_o and ts_req_o are low.
- R2: Bit 0 of the control word at byte offset 0xA00 enables collection. While it is 0, samples produce no element and no trigger, and external timestamp requests are ignored.
- R3: With control bit 1 at 0, the block runs in continuous mode. Every valid sample yields elem_valid_o high one cycle later, and elem_data_o equals that sample.
- R4: With control bit 1 at 1, the block runs in trace-on-change mode. A valid sample yields an element only if it differs from the last element produced. The first sample after collection is re-enabled always yields an element.
- R5: The trigger value words sit at 0xA18 (bits 31:0) and 0xA1C (bits 63:32), and the trigger mask words at 0xA20 and 0xA24. A mask bit of 1 compares the bit and 0 ignores it. trig_o pulses for one cycle, one cycle after each valid sample that matches.
- R6: The timestamp value words sit at 0xA08 and 0xA0C, and the timestamp mask words at 0xA10 and 0xA14. When bit 0 of the timestamp-enable word at 0xA04 is set, ts_req_o pulses one cycle after each valid sample that matches.
- R7: When bit 1 of 0xA04 is set and collection is enabled, xtrig_ts_req_i high produces ts_req_o high one cycle later, whether or not a sample is valid.
- R8: When bit 2 of 0xA04 is set, ts_req_o is high in the same cycle as every element on the element stream.
- R9: Mux-select word n sits at 0xA80 + 4n for n below MUX_CNT and reads back what was written. Offsets at or above the count read zero.
- R10: Unimplemented offsets read zero and ignore writes. Pattern and mask bits above ELEM_W read zero.
- R11: In trace-on-change mode the trigger still fires on a matching sample whose element is suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| smp_valid_i | input | 1 | Sample valid strobe |
| smp_data_i | input | ELEM_W | Sample value |
| xtrig_ts_req_i | input | 1 | External timestamp request |
| elem_valid_o | output | 1 | Trace element valid |
| elem_data_o | output | ELEM_W | Trace element value |
| ts_req_o | output | 1 | Timestamp request pulse |
| trig_o | output | 1 | Pattern trigger pulse |

## Verification
The bench builds the block with ELEM_W = 32 and MUX_CNT = 4. The 32-bit element width leaves the upper pattern and mask words unimplemented in hardware, so their forced-zero readback can be checked through the normal register port. A count of four makes offset 0xA90 the first word past the mux-select bank, which puts the bank boundary within reach. The element width also lets the bench feed arbitrary 32-bit values and reuse one value across both comparators and the change detector.

// File: rtl/mbt_pkg.sv
package mbt_pkg;
  localparam logic [11:0] OFF_CTRL  = 12'hA00;
  localparam logic [11:0] OFF_TSEN  = 12'hA04;
  localparam logic [11:0] OFF_TPAT0 = 12'hA08;
  localparam logic [11:0] OFF_TPAT1 = 12'hA0C;
  localparam logic [11:0] OFF_TMSK0 = 12'hA10;
  localparam logic [11:0] OFF_TMSK1 = 12'hA14;
  localparam logic [11:0] OFF_XPAT0 = 12'hA18;
  localparam logic [11:0] OFF_XPAT1 = 12'hA1C;
  localparam logic [11:0] OFF_XMSK0 = 12'hA20;
  localparam logic [11:0] OFF_XMSK1 = 12'hA24;
  localparam logic [11:0] OFF_MUX   = 12'hA80;

  typedef struct packed {
    logic ts_all;
    logic ts_xtrig;
    logic ts_patt;
  } tsen_t;
endpackage

// File: rtl/mbt_regs.sv
module mbt_regs
  import mbt_pkg::*;
#(
  parameter int ELEM_W  = 32,
  parameter int MUX_CNT = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [11:0]       addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              en_o,
  output logic              toc_o,
  output tsen_t             tsen_o,
  output logic [ELEM_W-1:0] tpat_o,
  output logic [ELEM_W-1:0] tmsk_o,
  output logic [ELEM_W-1:0] xpat_o,
  output logic [ELEM_W-1:0] xmsk_o
);
  localparam logic [63:0] KEEP = (ELEM_W == 64) ? {64{1'b1}}
                                                : ((64'd1 << ELEM_W) - 64'd1);

  logic [1:0]  ctrl_q;
  tsen_t       tsen_q;
  logic [63:0] tpat_q, tmsk_q, xpat_q, xmsk_q;
  logic [31:0] mux_rdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      tsen_q <= '0;
      tpat_q <= '0;
      tmsk_q <= '0;
      xpat_q <= '0;
      xmsk_q <= '0;
    end else if (wr_i) begin
      case (addr_i)
        OFF_CTRL:  ctrl_q         <= wdata_i[1:0];
        OFF_TSEN:  tsen_q         <= tsen_t'(wdata_i[2:0]);
        OFF_TPAT0: tpat_q[31:0]   <= wdata_i & KEEP[31:0];
        OFF_TPAT1: tpat_q[63:32]  <= wdata_i & KEEP[63:32];
        OFF_TMSK0: tmsk_q[31:0]   <= wdata_i & KEEP[31:0];
        OFF_TMSK1: tmsk_q[63:32]  <= wdata_i & KEEP[63:32];
        OFF_XPAT0: xpat_q[31:0]   <= wdata_i & KEEP[31:0];
        OFF_XPAT1: xpat_q[63:32]  <= wdata_i & KEEP[63:32];
        OFF_XMSK0: xmsk_q[31:0]   <= wdata_i & KEEP[31:0];
        OFF_XMSK1: xmsk_q[63:32]  <= wdata_i & KEEP[63:32];
        default: ;
      endcase
    end
  end

  generate
    if (MUX_CNT > 0) begin : g_mux
      logic [31:0] mux_q [MUX_CNT];

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < MUX_CNT; i++) mux_q[i] <= '0;
        end else if (wr_i) begin
          for (int i = 0; i < MUX_CNT; i++)
            if (addr_i == OFF_MUX + 12'(4 * i)) mux_q[i] <= wdata_i;
        end
      end

      always_comb begin
        mux_rdata = '0;
        for (int i = 0; i < MUX_CNT; i++)
          if (addr_i == OFF_MUX + 12'(4 * i)) mux_rdata = mux_q[i];
      end
    end else begin : g_no_mux
      assign mux_rdata = '0;
    end
  endgenerate

  always_comb begin
    case (addr_i)
      OFF_CTRL:  rdata_o = {30'b0, ctrl_q};
      OFF_TSEN:  rdata_o = {29'b0, tsen_q};
      OFF_TPAT0: rdata_o = tpat_q[31:0];
      OFF_TPAT1: rdata_o = tpat_q[63:32];
      OFF_TMSK0: rdata_o = tmsk_q[31:0];
      OFF_TMSK1: rdata_o = tmsk_q[63:32];
      OFF_XPAT0: rdata_o = xpat_q[31:0];
      OFF_XPAT1: rdata_o = xpat_q[63:32];
      OFF_XMSK0: rdata_o = xmsk_q[31:0];
      OFF_XMSK1: rdata_o = xmsk_q[63:32];
      default:   rdata_o = mux_rdata;
    endcase
  end

  assign en_o   = ctrl_q[0];
  assign toc_o  = ctrl_q[1];
  assign tsen_o = tsen_q;
  assign tpat_o = tpat_q[ELEM_W-1:0];
  assign tmsk_o = tmsk_q[ELEM_W-1:0];
  assign xpat_o = xpat_q[ELEM_W-1:0];
  assign xmsk_o = xmsk_q[ELEM_W-1:0];

  a_r1_ctrl_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFF_CTRL) |=> (en_o == $past(wdata_i[0])));
endmodule

// File: rtl/mbt_match.sv
module mbt_match #(
  parameter int W = 32
) (
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] pat_i,
  input  logic [W-1:0] msk_i,
  output logic         hit_o
);
  // mask bit 1 = compared, 0 = don't care
  assign hit_o = ~|((data_i ^ pat_i) & msk_i);
endmodule

// File: rtl/mbt_collect.sv
module mbt_collect #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         toc_i,
  input  logic         vld_i,
  input  logic [W-1:0] data_i,
  output logic         take_o,
  output logic         elem_valid_o,
  output logic [W-1:0] elem_data_o
);
  logic [W-1:0] ref_q;
  logic         ref_vld_q;
  logic         acc;

  assign acc    = en_i & vld_i;
  assign take_o = acc & (~toc_i | ~ref_vld_q | (data_i != ref_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q        <= '0;
      ref_vld_q    <= 1'b0;
      elem_valid_o <= 1'b0;
      elem_data_o  <= '0;
    end else begin
      elem_valid_o <= take_o;
      if (take_o) elem_data_o <= data_i;
      if (!en_i) begin
        ref_vld_q <= 1'b0;
      end else if (take_o) begin
        ref_vld_q <= 1'b1;
        ref_q     <= data_i;
      end
    end
  end

  a_r2_off_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !elem_valid_o);
  a_r3_cont_every: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !toc_i && vld_i) |=> (elem_valid_o && elem_data_o == $past(data_i)));
  a_r4_toc_repeat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && toc_i && vld_i && elem_valid_o && data_i == elem_data_o) |=> !elem_valid_o);
endmodule

// File: rtl/mbit_trace_monitor.sv
module mbit_trace_monitor
  import mbt_pkg::*;
#(
  parameter int ELEM_W  = 32,
  parameter int MUX_CNT = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [11:0]       reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              smp_valid_i,
  input  logic [ELEM_W-1:0] smp_data_i,
  input  logic              xtrig_ts_req_i,
  output logic              elem_valid_o,
  output logic [ELEM_W-1:0] elem_data_o,
  output logic              ts_req_o,
  output logic              trig_o
);
  logic              en, toc, take, t_hit, x_hit, acc;
  tsen_t             tsen;
  logic [ELEM_W-1:0] tpat, tmsk, xpat, xmsk;

  mbt_regs #(.ELEM_W(ELEM_W), .MUX_CNT(MUX_CNT)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .en_o(en), .toc_o(toc), .tsen_o(tsen),
    .tpat_o(tpat), .tmsk_o(tmsk), .xpat_o(xpat), .xmsk_o(xmsk)
  );

  mbt_collect #(.W(ELEM_W)) u_collect (
    .clk_i, .rst_ni,
    .en_i(en), .toc_i(toc), .vld_i(smp_valid_i), .data_i(smp_data_i),
    .take_o(take), .elem_valid_o, .elem_data_o
  );

  mbt_match #(.W(ELEM_W)) u_ts_match (
    .data_i(smp_data_i), .pat_i(tpat), .msk_i(tmsk), .hit_o(t_hit)
  );

  mbt_match #(.W(ELEM_W)) u_trig_match (
    .data_i(smp_data_i), .pat_i(xpat), .msk_i(xmsk), .hit_o(x_hit)
  );

  assign acc = en & smp_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_o   <= 1'b0;
      ts_req_o <= 1'b0;
    end else begin
      trig_o   <= acc & x_hit;
      ts_req_o <= (acc & tsen.ts_patt & t_hit)
                | (tsen.ts_all & take)
                | (tsen.ts_xtrig & en & xtrig_ts_req_i);
    end
  end

  a_r5_trig_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> !trig_o);
  a_r7_xtrig_ts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && tsen.ts_xtrig && xtrig_ts_req_i) |=> ts_req_o);
  a_r8_ts_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tsen.ts_all && take) |=> (ts_req_o && elem_valid_o));
endmodule

// File: tb/mbit_trace_monitor_tb_top.sv
module mbit_trace_monitor_tb_top;
  localparam int W = 32;
  localparam int MC = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_wr_i = 1'b0;
  logic [11:0]   reg_addr_i = '0;
  logic [31:0]   reg_wdata_i = '0;
  logic [31:0]   reg_rdata_o;
  logic          smp_valid_i = 1'b0;
  logic [W-1:0]  smp_data_i = '0;
  logic          xtrig_ts_req_i = 1'b0;
  logic          elem_valid_o;
  logic [W-1:0]  elem_data_o;
  logic          ts_req_o;
  logic          trig_o;

  always #5 clk_i = ~clk_i;

  mbit_trace_monitor #(.ELEM_W(W), .MUX_CNT(MC)) dut_i (.*);

  typedef struct {
    logic         v;
    logic [W-1:0] d;
    logic         trig;
    logic         ts;
    string        tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench-side model state
  logic         m_en = 0, m_toc = 0, m_rvld = 0;
  logic [2:0]   m_tsen = 0;
  logic [W-1:0] m_tp = 0, m_tm = 0, m_xp = 0, m_xm = 0, m_ref = 0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk_i);
    smp_valid_i = 0; xtrig_ts_req_i = 0;
    reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 0;
    case (a)
      12'hA00: begin m_en = d[0]; m_toc = d[1]; if (!d[0]) m_rvld = 0; end
      12'hA04: m_tsen = d[2:0];
      12'hA08: m_tp = d;
      12'hA10: m_tm = d;
      12'hA18: m_xp = d;
      12'hA20: m_xm = d;
      default: ;
    endcase
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk_i);
    smp_valid_i = 0; xtrig_ts_req_i = 0; reg_wr_i = 0; reg_addr_i = a;
    #1;
    chk(tag, $sformatf("read %0h", a), 64'(reg_rdata_o), 64'(exp));
  endtask

  task automatic step(logic v, logic [W-1:0] d, logic x, string tag);
    exp_t e;
    logic acc, take;
    @(negedge clk_i);
    smp_valid_i = v; smp_data_i = d; xtrig_ts_req_i = x;
    acc  = m_en & v;
    take = acc & (!m_toc || !m_rvld || d != m_ref);
    e.v    = take;
    e.d    = d;
    e.trig = acc & (((d ^ m_xp) & m_xm) == 0);
    e.ts   = (acc & m_tsen[0] & (((d ^ m_tp) & m_tm) == 0))
           | (m_tsen[2] & take) | (m_tsen[1] & m_en & x);
    e.tag  = tag;
    if (take) begin m_rvld = 1; m_ref = d; end
    q.push_back(e);
  endtask

  // monitor: compares the item pushed before the preceding edge
  always @(posedge clk_i) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "elem_valid", 64'(elem_valid_o), 64'(e.v));
      if (e.v) chk(e.tag, "elem_data", 64'(elem_data_o), 64'(e.d));
      chk(e.tag, "trig", 64'(trig_o), 64'(e.trig));
      chk(e.tag, "ts_req", 64'(ts_req_o), 64'(e.ts));
    end
  end

  initial begin
    #(10 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1", "elem_valid", 64'(elem_valid_o), 0);
    chk("R1", "trig", 64'(trig_o), 0);
    chk("R1", "ts_req", 64'(ts_req_o), 0);
    rst_ni = 1;
    rd(12'hA00, 0, "R1");
    rd(12'hA18, 0, "R1");
    rd(12'hA80, 0, "R1");

    // R2: disabled, nothing comes out, external request ignored
    wr(12'hA04, 32'h2);
    step(1, 32'h11, 1, "R2");
    step(1, 32'h22, 0, "R2");
    step(0, 32'h0, 0, "R2");
    wr(12'hA04, 32'h0);

    // R3: continuous, repeats included; mask 0 so trigger on each sample
    wr(12'hA00, 32'h1);
    step(1, 32'h5, 0, "R3");
    step(1, 32'h5, 0, "R3");
    step(0, 32'h9, 0, "R3");
    step(1, 32'hDEADBEEF, 0, "R3");
    step(1, 32'hDEADBEEF, 0, "R3");
    step(0, 32'h0, 0, "R3");

    // R5: masked trigger pattern
    wr(12'hA18, 32'h0000_00A5);
    wr(12'hA20, 32'h0000_00FF);
    rd(12'hA18, 32'h0000_00A5, "R5");
    step(1, 32'h1234_56A5, 0, "R5");
    step(1, 32'h1234_56A4, 0, "R5");
    step(1, 32'hFFFF_FFA5, 0, "R5");
    step(0, 32'h0000_00A5, 0, "R5");
    step(0, 32'h0, 0, "R5");

    // R4 / R11: trace-on-change
    wr(12'hA00, 32'h3);
    step(1, 32'hFFFF_FFA5, 0, "R11");
    step(1, 32'h0000_00A5, 0, "R4");
    step(1, 32'h0000_00A5, 0, "R11");
    step(1, 32'h0000_0001, 0, "R4");
    step(1, 32'h0000_0001, 0, "R4");
    step(1, 32'h0000_00A5, 0, "R4");
    step(0, 32'h0, 0, "R4");
    wr(12'hA00, 32'h0);
    step(1, 32'h0000_00A5, 0, "R2");
    step(0, 32'h0, 0, "R2");
    wr(12'hA00, 32'h3);
    step(1, 32'h0000_00A5, 0, "R4");
    step(1, 32'h0000_00A5, 0, "R4");
    step(0, 32'h0, 0, "R4");

    // R6: timestamp pattern
    wr(12'hA00, 32'h1);
    wr(12'hA08, 32'h0000_3C00);
    wr(12'hA10, 32'h0000_FF00);
    wr(12'hA04, 32'h1);
    rd(12'hA04, 32'h1, "R6");
    step(1, 32'h0000_3C77, 0, "R6");
    step(1, 32'h0000_3D77, 0, "R6");
    step(0, 32'h0000_3C00, 0, "R6");
    step(1, 32'hABCD_3C00, 1, "R6");
    step(0, 32'h0, 0, "R6");

    // R7: external timestamp request
    wr(12'hA04, 32'h2);
    step(0, 32'h0, 1, "R7");
    step(1, 32'h0000_3C00, 0, "R7");
    step(0, 32'h0, 1, "R7");
    step(0, 32'h0, 0, "R7");

    // R8: timestamp every element, under trace-on-change
    wr(12'hA00, 32'h3);
    wr(12'hA04, 32'h4);
    step(1, 32'h77, 0, "R8");
    step(1, 32'h77, 0, "R8");
    step(1, 32'h78, 0, "R8");
    step(0, 32'h0, 0, "R8");

    // R9: mux-select bank
    for (int i = 0; i < MC + 1; i++) wr(12'hA80 + 12'(4 * i), 32'hC0DE_0000 + i);
    for (int i = 0; i < MC; i++) rd(12'hA80 + 12'(4 * i), 32'hC0DE_0000 + i, "R9");
    rd(12'hA80 + 12'(4 * MC), 0, "R9");

    // R10: holes and bits above the element width
    wr(12'hA28, 32'hFFFF_FFFF);
    rd(12'hA28, 0, "R10");
    wr(12'hA0C, 32'hFFFF_FFFF);
    rd(12'hA0C, 0, "R10");
    wr(12'hA24, 32'h1234_5678);
    rd(12'hA24, 0, "R10");
    rd(12'hA02, 0, "R10");
    rd(12'hA08, 32'h0000_3C00, "R10");

    repeat (3) @(negedge clk_i);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule